// File: doc/BRIEF.md
# Three-Phase Gate-Drive Protection Core

This block is the digital control core of a three-phase half-bridge gate driver. Each phase has one high-side and one low-side command input. Both are active low. Every command passes through a two-flop synchronizer and a glitch filter, and the high-side filter is longer so that very short on-pulses are dropped. A per-phase state machine then turns the filtered request into gate enables. It holds both switches of the phase off for a fixed dead interval before any switch turns on. When both commands of a phase are asserted together, it refuses to turn either switch on.

A fault state machine watches a synchronized overcurrent comparator bit and two synchronized undervoltage bits. The undervoltage bits cover the logic supply and the high-side supplies. The trip bit is ignored for a blanking window after any gate turns on. A valid trip latches a fault that switches off all gates and pulls the active-low fault flag low. The latch releases only after all low-side commands have stayed released for a full clear interval. An undervoltage forces the same shutdown but does not latch. After any fault, a phase stays locked off until its own commands have been released, so that only a fresh command can drive it again. All durations are clock-cycle parameters.

Phase states: `PH_OFF` (idle, both gates off), `PH_DEAD` (both off, dead interval counting toward a pending side), `PH_HIGH` (high gate on), `PH_LOW` (low gate on), `PH_LOCK` (forced off by a fault). Phase transitions:
- OFF→DEAD on a single-side request.
- DEAD→HIGH or DEAD→LOW when the dead count completes.
- DEAD restarts its count when the requested side changes.
- DEAD→OFF when the request drops or both sides are requested.
- HIGH or LOW→DEAD when the other side is requested.
- HIGH or LOW→OFF when no single side is requested.
- Any state→LOCK while a fault is active.
- LOCK→OFF once the fault is gone and the phase has no request.

Fault states: `FS_RUN` (normal), `FS_TRIP` (latched overcurrent, clear counter running), `FS_UV` (supply low). Fault transitions:
- RUN→UV on undervoltage. Undervoltage takes priority over a trip.
- RUN→TRIP on an unblanked trip.
- TRIP→RUN, or TRIP→UV, when the clear count completes.
- TRIP restarts its clear count on any low-side request.
- UV→RUN when both undervoltage bits are low.

Top module: `gate_drive_guard`

## Requirements
- R1: Command inputs are active low. A held low level on `lin_n[p]` turns on `lo_gate[p]`, and a held low level on `hin_n[p]` turns on `hi_gate[p]`. A high level turns the gate off. From a low edge on an idle low-side input, the gate rises after 2 + LO_FILT_CYC + 1 + DEAD_CYC clock cycles (within one cycle).
- R2: A low-side command pulse shorter than LO_FILT_CYC cycles never changes any gate.
- R3: A high-side command pulse shorter than HI_FILT_CYC cycles never turns on its high gate. A longer command does turn it on.
- R4: Every gate turn-on is preceded by at least DEAD_CYC consecutive cycles in which both gates of that phase are off. The two gates of a phase are never on together.
- R5: While both commands of a phase are active, both of its gates are off. When one command is then released, the other side turns on after the dead interval.
- R6: The trip input is ignored for BLANK_CYC cycles after any gate turns on.
- R7: An unblanked trip turns all gates off and drives `fault_n` low. The fault stays latched after the trip input returns low.
- R8: A latched trip clears only after all low-side commands have been continuously released for CLR_CYC cycles after filtering. Any low-side request during this interval restarts the count.
- R9: While any fault is active, commands do not turn gates on. After the fault ends, a phase whose command is still held stays off. The phase turns on again only after the command has been released and applied again.
- R10: Either undervoltage bit drives all gates off and pulls `fault_n` low. `fault_n` returns high, without any latch, once both bits are low.
- R11: After reset, all gates are off and `fault_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hin_n | input | N_PHASE | High-side commands, active low, asynchronous |
| lin_n | input | N_PHASE | Low-side commands, active low, asynchronous |
| itrip | input | 1 | Overcurrent comparator, high = overcurrent |
| uv_logic | input | 1 | Logic/low-side supply undervoltage, high = low supply |
| uv_high | input | 1 | High-side supply undervoltage, high = low supply |
| hi_gate | output | N_PHASE | High-side gate enables, high = on |
| lo_gate | output | N_PHASE | Low-side gate enables, high = on |
| fault_n | output | 1 | Fault flag, low = trip or undervoltage active |

## Verification
The bench measures the exact latency from a low-side command to its gate. A design that skipped the synchronizer, the filter or the dead count would show up as too short. A per-cycle monitor catches any turn-on with a short off-gap, and any overlap of the two gates in a phase. Directed tasks fire:
- glitches just under each filter length, which a wrong filter would let through;
- a trip pulse inside the blanking window, which a missing blank would turn into a fault;
- a low-side press midway through the clear interval, which a counter that does not restart would ignore and so clear the fault early.

Further tasks hold a command through a fault and through an undervoltage. A design that resumed on a held command would turn the gate back on with no new edge. Another design would keep the flag low after the undervoltage bit drops, and the same tasks catch it.

// File: rtl/gdp_pkg.sv
package gdp_pkg;

    typedef enum logic [2:0] {
        PH_OFF  = 3'd0,
        PH_DEAD = 3'd1,
        PH_HIGH = 3'd2,
        PH_LOW  = 3'd3,
        PH_LOCK = 3'd4
    } phase_st_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_HIGH = 2'd1,
        TGT_LOW  = 2'd2
    } target_e;

    typedef enum logic [1:0] {
        FS_RUN  = 2'd0,
        FS_TRIP = 2'd1,
        FS_UV   = 2'd2
    } fault_st_e;

endpackage

// File: rtl/gdp_sync.sv
module gdp_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/gdp_glitch_filter.sv
module gdp_glitch_filter #(
    parameter int   CYC     = 4,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic          s;
    logic          q_q;
    logic [CW-1:0] cnt_q;

    gdp_sync #(.RST_VAL(RST_VAL)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (d_async),
        .q     (s)
    );

    // Output follows the synced level only after CYC differing cycles in a row
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q   <= RST_VAL;
            cnt_q <= '0;
        end else if (s != q_q) begin
            if (cnt_q == LAST) begin
                q_q   <= s;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign q = q_q;

    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q != $past(q_q)) |-> ($past(s) == q_q)); // R2
endmodule

// File: rtl/gdp_phase_fsm.sv
module gdp_phase_fsm
    import gdp_pkg::*;
#(
    parameter int DEAD_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_req,
    input  logic lo_req,
    input  logic kill,
    output logic hi_on,
    output logic lo_on,
    output logic turn_on
);
    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] DEAD_LAST = DW'(DEAD_CYC - 1);

    phase_st_e     st_q, st_d;
    target_e       pend_q, pend_d;
    target_e       tgt;
    logic [DW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (hi_req && !lo_req)      tgt = TGT_HIGH;
        else if (lo_req && !hi_req) tgt = TGT_LOW;
        else                        tgt = TGT_NONE;
    end

    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        cnt_d  = cnt_q;
        unique case (st_q)
            PH_LOCK: begin
                if (!kill && tgt == TGT_NONE) st_d = PH_OFF;
            end
            PH_OFF: begin
                if (kill) st_d = PH_LOCK;
                else if (tgt != TGT_NONE) begin
                    st_d   = PH_DEAD;
                    pend_d = tgt;
                    cnt_d  = '0;
                end
            end
            PH_DEAD: begin
                if (kill) st_d = PH_LOCK;
                else if (tgt == TGT_NONE) st_d = PH_OFF;
                else if (tgt != pend_q) begin
                    pend_d = tgt;
                    cnt_d  = '0;
                end else if (cnt_q == DEAD_LAST) begin
                    st_d = (pend_q == TGT_HIGH) ? PH_HIGH : PH_LOW;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_HIGH, PH_LOW: begin
                if (kill) st_d = PH_LOCK;
                else if (tgt == TGT_NONE) st_d = PH_OFF;
                else if ((st_q == PH_HIGH) != (tgt == TGT_HIGH)) begin
                    st_d   = PH_DEAD;
                    pend_d = tgt;
                    cnt_d  = '0;
                end
            end
            default: st_d = PH_LOCK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PH_OFF;
            pend_q <= TGT_NONE;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
            cnt_q  <= cnt_d;
        end
    end

    always_comb begin
        hi_on   = (st_q == PH_HIGH);
        lo_on   = (st_q == PH_LOW);
        turn_on = (st_q == PH_DEAD) && ((st_d == PH_HIGH) || (st_d == PH_LOW));
    end

    // Checker: consecutive both-off cycles, saturating at DEAD_CYC
    logic [DW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= '0;
        else if (hi_on || lo_on) gap_q <= '0;
        else if (gap_q != DW'(DEAD_CYC)) gap_q <= gap_q + 1'b1;
    end

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_on || lo_on) |-> (int'(gap_q) >= DEAD_CYC)); // R4
    AST_KILL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!hi_on && !lo_on)); // R9
    AST_BOTH_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_req && lo_req) |=> (!hi_on && !lo_on)); // R5
endmodule

// File: rtl/gdp_fault_fsm.sv
module gdp_fault_fsm
    import gdp_pkg::*;
#(
    parameter int BLANK_CYC = 8,
    parameter int CLR_CYC   = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_s,
    input  logic uv_s,
    input  logic lo_any,
    input  logic on_any,
    output logic kill,
    output logic fault_n
);
    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam int CW = $clog2(CLR_CYC + 1);
    localparam logic [BW-1:0] BLANK_VAL = BW'(BLANK_CYC);
    localparam logic [CW-1:0] CLR_LAST  = CW'(CLR_CYC - 1);

    fault_st_e     st_q, st_d;
    logic [CW-1:0] clr_q, clr_d;
    logic [BW-1:0] blank_q, blank_d;

    always_comb begin
        if (on_any)             blank_d = BLANK_VAL;
        else if (blank_q != '0) blank_d = blank_q - 1'b1;
        else                    blank_d = '0;
    end

    always_comb begin
        st_d  = st_q;
        clr_d = clr_q;
        unique case (st_q)
            FS_RUN: begin
                clr_d = '0;
                if (uv_s) st_d = FS_UV;
                else if (trip_s && blank_q == '0) st_d = FS_TRIP;
            end
            FS_TRIP: begin
                if (lo_any) clr_d = '0;
                else if (clr_q == CLR_LAST) begin
                    st_d  = uv_s ? FS_UV : FS_RUN;
                    clr_d = '0;
                end else begin
                    clr_d = clr_q + 1'b1;
                end
            end
            FS_UV: begin
                if (!uv_s) st_d = FS_RUN;
            end
            default: st_d = FS_TRIP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= FS_RUN;
            clr_q   <= '0;
            blank_q <= '0;
        end else begin
            st_q    <= st_d;
            clr_q   <= clr_d;
            blank_q <= blank_d;
        end
    end

    always_comb begin
        kill    = (st_q != FS_RUN);
        fault_n = (st_q == FS_RUN);
    end

    AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_TRIP && lo_any) |=> (st_q == FS_TRIP)); // R8
    AST_BLANK_RESPECT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_TRIP && $past(st_q) == FS_RUN) |-> ($past(blank_q) == '0)); // R6
    AST_UV_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> (st_q != FS_RUN)); // R10
endmodule

// File: rtl/gate_drive_guard.sv
module gate_drive_guard #(
    parameter int N_PHASE     = 3,
    parameter int LO_FILT_CYC = 31,
    parameter int HI_FILT_CYC = 150,
    parameter int DEAD_CYC    = 250,
    parameter int BLANK_CYC   = 40,
    parameter int CLR_CYC     = 900
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PHASE-1:0] hin_n,
    input  logic [N_PHASE-1:0] lin_n,
    input  logic               itrip,
    input  logic               uv_logic,
    input  logic               uv_high,
    output logic [N_PHASE-1:0] hi_gate,
    output logic [N_PHASE-1:0] lo_gate,
    output logic               fault_n
);
    logic [N_PHASE-1:0] hin_f_n;
    logic [N_PHASE-1:0] lin_f_n;
    logic [N_PHASE-1:0] turn_on;
    logic               trip_s;
    logic               uvl_s;
    logic               uvh_s;
    logic               kill;

    for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
        gdp_glitch_filter #(.CYC(HI_FILT_CYC), .RST_VAL(1'b1)) i_hi_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (hin_n[p]),
            .q       (hin_f_n[p])
        );
        gdp_glitch_filter #(.CYC(LO_FILT_CYC), .RST_VAL(1'b1)) i_lo_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (lin_n[p]),
            .q       (lin_f_n[p])
        );
        gdp_phase_fsm #(.DEAD_CYC(DEAD_CYC)) i_phase (
            .clk     (clk),
            .rst_n   (rst_n),
            .hi_req  (!hin_f_n[p]),
            .lo_req  (!lin_f_n[p]),
            .kill    (kill),
            .hi_on   (hi_gate[p]),
            .lo_on   (lo_gate[p]),
            .turn_on (turn_on[p])
        );
    end

    gdp_sync #(.RST_VAL(1'b0)) i_trip_sync (
        .clk(clk), .rst_n(rst_n), .d(itrip), .q(trip_s)
    );
    gdp_sync #(.RST_VAL(1'b0)) i_uvl_sync (
        .clk(clk), .rst_n(rst_n), .d(uv_logic), .q(uvl_s)
    );
    gdp_sync #(.RST_VAL(1'b0)) i_uvh_sync (
        .clk(clk), .rst_n(rst_n), .d(uv_high), .q(uvh_s)
    );

    gdp_fault_fsm #(.BLANK_CYC(BLANK_CYC), .CLR_CYC(CLR_CYC)) i_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip_s  (trip_s),
        .uv_s    (uvl_s || uvh_s),
        .lo_any  (!(&lin_f_n)),
        .on_any  (|turn_on),
        .kill    (kill),
        .fault_n (fault_n)
    );

    AST_FAULT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && !$past(fault_n)) |-> (hi_gate == '0 && lo_gate == '0)); // R7
endmodule

// File: tb/test_gate_drive_guard.sv
module test_gate_drive_guard;
    localparam int NP    = 3;
    localparam int LOF   = 4;
    localparam int HIF   = 12;
    localparam int DEAD  = 10;
    localparam int BLANK = 8;
    localparam int CLR   = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] hin_n = '1;
    logic [NP-1:0] lin_n = '1;
    logic          itrip = 1'b0;
    logic          uv_logic = 1'b0;
    logic          uv_high = 1'b0;
    logic [NP-1:0] hi_gate;
    logic [NP-1:0] lo_gate;
    logic          fault_n;

    int n_checks = 0;
    int n_fail   = 0;
    int mon_bad  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    gate_drive_guard #(
        .N_PHASE(NP), .LO_FILT_CYC(LOF), .HI_FILT_CYC(HIF),
        .DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .CLR_CYC(CLR)
    ) i_gate_drive_guard (
        .clk(clk), .rst_n(rst_n), .hin_n(hin_n), .lin_n(lin_n),
        .itrip(itrip), .uv_logic(uv_logic), .uv_high(uv_high),
        .hi_gate(hi_gate), .lo_gate(lo_gate), .fault_n(fault_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R4 monitor: off-gap before every turn-on, and no overlap
    int gap [NP];
    bit prev_on [NP];
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                gap[p] = 0;
                prev_on[p] = 1'b0;
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                bit on;
                on = hi_gate[p] || lo_gate[p];
                if (hi_gate[p] && lo_gate[p]) mon_bad++;
                if (on && !prev_on[p] && gap[p] < DEAD) mon_bad++;
                if (on) gap[p] = 0;
                else gap[p] = gap[p] + 1;
                prev_on[p] = on;
            end
        end
    end

    task automatic t_reset;
        tick(3);
        check(hi_gate == '0, "R11 hi_gate after reset", int'(hi_gate), 0);
        check(lo_gate == '0, "R11 lo_gate after reset", int'(lo_gate), 0);
        check(fault_n == 1'b1, "R11 fault_n after reset", int'(fault_n), 1);
    endtask

    task automatic t_latency_low;
        int n = 0;
        int exp_lat = 2 + LOF + 1 + DEAD;
        lin_n[0] = 1'b0;
        while (!lo_gate[0] && n < 100) begin
            tick(1);
            n++;
        end
        check(n >= exp_lat - 1 && n <= exp_lat + 1, "R1 low-side turn-on latency", n, exp_lat);
        check(hi_gate[0] == 1'b0, "R1 high side stays off", int'(hi_gate[0]), 0);
        lin_n[0] = 1'b1;
        tick(20);
        check(lo_gate[0] == 1'b0, "R1 release turns off", int'(lo_gate[0]), 0);
    endtask

    task automatic t_glitch_low;
        int seen = 0;
        lin_n[1] = 1'b0;
        tick(LOF - 2);
        lin_n[1] = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tick(1);
            if (lo_gate != '0 || hi_gate != '0) seen++;
        end
        check(seen == 0, "R2 short low-side pulse filtered", seen, 0);
    endtask

    task automatic t_high_side;
        int seen = 0;
        hin_n[2] = 1'b0;
        tick(HIF - 4);
        hin_n[2] = 1'b1;
        for (int i = 0; i < 50; i++) begin
            tick(1);
            if (hi_gate[2]) seen++;
        end
        check(seen == 0, "R3 short high-side pulse filtered", seen, 0);
        hin_n[2] = 1'b0;
        tick(HIF + DEAD + 10);
        check(hi_gate[2] == 1'b1, "R3 long high-side command passes", int'(hi_gate[2]), 1);
        hin_n[2] = 1'b1;
        tick(30);
    endtask

    task automatic t_both;
        hin_n[0] = 1'b0;
        lin_n[0] = 1'b0;
        tick(60);
        check(hi_gate[0] == 1'b0 && lo_gate[0] == 1'b0, "R5 both requested gives both off",
              int'({hi_gate[0], lo_gate[0]}), 0);
        lin_n[0] = 1'b1;
        tick(30);
        check(hi_gate[0] == 1'b1, "R5 remaining side turns on", int'(hi_gate[0]), 1);
        hin_n[0] = 1'b1;
        tick(30);
    endtask

    task automatic t_blank_trip_clear;
        int n = 0;
        lin_n[1] = 1'b0;
        tick(DEAD + LOF + 10);
        hin_n[0] = 1'b0;
        while (!hi_gate[0] && n < 100) begin
            tick(1);
            n++;
        end
        itrip = 1'b1;
        tick(3);
        itrip = 1'b0;
        tick(12);
        check(fault_n == 1'b1, "R6 trip inside blanking ignored", int'(fault_n), 1);
        check(hi_gate[0] == 1'b1, "R6 gate kept on during blanking", int'(hi_gate[0]), 1);
        itrip = 1'b1;
        tick(10);
        check(fault_n == 1'b0, "R7 trip asserts fault", int'(fault_n), 0);
        check(hi_gate == '0 && lo_gate == '0, "R7 trip turns all off",
              int'({hi_gate, lo_gate}), 0);
        itrip = 1'b0;
        hin_n[2] = 1'b0;
        tick(25);
        check(fault_n == 1'b0, "R7 fault latched after trip drops", int'(fault_n), 0);
        check(hi_gate[2] == 1'b0, "R9 command ignored during fault", int'(hi_gate[2]), 0);
        // release low side, then press midway to restart the count
        lin_n[1] = 1'b1;
        tick(20);
        lin_n[0] = 1'b0;
        tick(10);
        lin_n[0] = 1'b1;
        tick(CLR - 5);
        check(fault_n == 1'b0, "R8 low press restarts clear count", int'(fault_n), 0);
        tick(25);
        check(fault_n == 1'b1, "R8 fault clears after interval", int'(fault_n), 1);
        tick(DEAD + 10);
        check(hi_gate[0] == 1'b0 && hi_gate[2] == 1'b0, "R9 held command stays off after clear",
              int'({hi_gate[0], hi_gate[2]}), 0);
        hin_n[2] = 1'b1;
        tick(30);
        hin_n[2] = 1'b0;
        tick(HIF + DEAD + 15);
        check(hi_gate[2] == 1'b1, "R9 fresh command turns on after clear", int'(hi_gate[2]), 1);
        hin_n = '1;
        tick(40);
    endtask

    task automatic t_uv;
        hin_n[1] = 1'b0;
        tick(HIF + DEAD + 15);
        uv_logic = 1'b1;
        tick(8);
        check(fault_n == 1'b0, "R10 logic undervoltage flags fault", int'(fault_n), 0);
        check(hi_gate[1] == 1'b0, "R10 logic undervoltage turns off", int'(hi_gate[1]), 0);
        uv_logic = 1'b0;
        tick(8);
        check(fault_n == 1'b1, "R10 undervoltage not latched", int'(fault_n), 1);
        tick(DEAD + 10);
        check(hi_gate[1] == 1'b0, "R9 held command stays off after undervoltage",
              int'(hi_gate[1]), 0);
        hin_n[1] = 1'b1;
        tick(30);
        hin_n[1] = 1'b0;
        tick(HIF + DEAD + 15);
        check(hi_gate[1] == 1'b1, "R9 fresh command after undervoltage", int'(hi_gate[1]), 1);
        uv_high = 1'b1;
        tick(8);
        check(fault_n == 1'b0 && hi_gate[1] == 1'b0, "R10 high-side undervoltage",
              int'({fault_n, hi_gate[1]}), 0);
        uv_high = 1'b0;
        tick(8);
        check(fault_n == 1'b1, "R10 high-side undervoltage clears", int'(fault_n), 1);
        hin_n = '1;
        tick(30);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        t_reset();
        t_latency_low();
        t_glitch_low();
        t_high_side();
        t_both();
        t_blank_trip_clear();
        t_uv();
        check(mon_bad == 0, "R4 dead gap and no overlap monitor", mon_bad, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule